// File: doc/BRIEF.md
# Two-Colour Hardware Cursor Overlay

This block lays a 64x64 pixel, two-colour cursor over a live pixel stream. Every clock the raster logic presents the coordinates of the pixel being produced. The overlay decides whether that pixel falls inside the cursor square. If it does, it looks up a 2-bit code in an internal two-plane image and returns a flag, a transparency indication and a 24-bit colour. The downstream mixer uses these to replace or keep the underlying pixel. Results appear one clock after the coordinates.

The cursor position is held outside the block as two 12-bit values and is biased by the cursor size. Each value names the coordinate just past the cursor's far edge, so a cursor partly off the top or left of the screen can still be expressed with unsigned numbers. A single byte-wide write port loads three things: the 1024-byte image, made of two 512-byte planes stored one after the other; a three-entry colour table; and the table index. The table is filled with auto-incrementing R, G, B byte triplets. Entry 0 is a border (overscan) colour and is presented continuously on its own output. An interlace control makes the vertical position ignore its lowest bit.

Top module: `cursor_overlay`

## Requirements
- R1: While rst_n is low at a clock edge, curs_act and curs_transp go low, curs_rgb and ovs_rgb go to zero, every colour table entry clears, the colour index returns to 0 and the byte counter returns to 0.
- R2: With position values PX and PY, the pixel at (pix_x, pix_y) is inside the cursor when PX-64 <= pix_x <= PX-1 and PY-64 <= pix_y <= PY-1. The outputs for a pixel appear one clock after its coordinates are sampled.
- R3: Inside the cursor, the column offset c is pix_x-(PX-64) and the row offset r is pix_y-(PY-64). The plane-0 bit is taken from image byte r*8+c/8. The plane-1 bit is taken from byte 512+r*8+c/8. Within a byte, bit 7 is the leftmost of its eight pixels.
- R4: The code {plane1,plane0} selects the output. 11 gives the foreground, table entry 2. 10 gives the background, table entry 1. 00 and 01 are transparent: curs_act is high, curs_transp is high and curs_rgb is zero.
- R5: When mode is 00, curs_act stays low. Any non-zero mode enables the two-colour overlay.
- R6: When pix_vld is low, curs_act is low for that pixel.
- R7: When interlace is high, bit 0 of the vertical position is treated as 0.
- R8: A write with wr_kind 01 sets the colour index to wr_data[1:0] (a value of 3 selects 0) and clears the byte counter. Each write with wr_kind 10 stores wr_data into the current entry in the order R, G, B. After the third byte the index moves to the next entry, wrapping from 2 back to 0. A write with wr_kind 00 stores wr_data at image byte wr_addr.
- R9: ovs_rgb always shows table entry 0 as {R,G,B}, from the clock after the write that completes it.
- R10: The full 12-bit range works for both the coordinates and the positions. A position below 64 places the cursor partly before column or row 0, and the part that remains visible keeps its correct offsets.
- R11: curs_rgb is zero whenever curs_act is low or curs_transp is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_x | input | 12 | Column of the current pixel |
| pix_y | input | 12 | Row of the current pixel |
| pix_vld | input | 1 | Current pixel is in the visible area |
| pos_x | input | 12 | Biased horizontal cursor position (right edge + 1) |
| pos_y | input | 12 | Biased vertical cursor position (bottom edge + 1) |
| mode | input | 2 | Cursor mode, 00 disables the overlay |
| interlace | input | 1 | Ignore bit 0 of pos_y |
| wr_en | input | 1 | Write strobe for the load port |
| wr_kind | input | 2 | 00 image byte, 01 colour index, 10 colour byte, 11 no effect |
| wr_addr | input | 10 | Image byte address, bit 9 selects plane 1 |
| wr_data | input | 8 | Write data |
| curs_act | output | 1 | Pixel lies inside an enabled cursor |
| curs_transp | output | 1 | Cursor pixel is transparent |
| curs_rgb | output | 24 | Cursor colour {R,G,B} |
| ovs_rgb | output | 24 | Colour table entry 0 {R,G,B} |

## Verification
The assertions assume that wr_kind is one of the defined encodings whenever wr_en is high. They also assume that mode and pix_vld are stable for each pixel they qualify, so that a mode of 00 or an invalid pixel in one cycle can be related to a quiet output in the next. The stimulus changes inputs only on falling edges and holds each pixel for a full clock. It loads the whole image, including zero bytes, before reading any cursor pixel, so no image location is read before it has been written.

// File: rtl/cursor_pkg.sv
// Shared types for the cursor overlay.
// Assumes an 8-bit byte write port and 8-bit colour components.
package cursor_pkg;

    // Kind of access on the load port
    typedef enum logic [1:0] {
        WR_IMAGE     = 2'b00,
        WR_CLUT_IDX  = 2'b01,
        WR_CLUT_DATA = 2'b10,
        WR_NONE      = 2'b11
    } wr_kind_e;

    // Colour table entry, red in the most significant byte
    typedef struct packed {
        logic [7:0] r;
        logic [7:0] g;
        logic [7:0] b;
    } rgb_t;

    localparam int CLUT_ENTRIES = 3;
    localparam logic [1:0] CLUT_LAST = 2'(CLUT_ENTRIES - 1);
    localparam logic [1:0] IDX_OVS   = 2'd0;
    localparam logic [1:0] IDX_BACK  = 2'd1;
    localparam logic [1:0] IDX_FORE  = 2'd2;

    // A pixel code is opaque when the mask plane (plane 1) is set
    function automatic logic code_opaque(input logic [1:0] code);
        return code[1];
    endfunction

endpackage

// File: rtl/cursor_locate.sv
// Window test for the cursor square.
// The position inputs point one past the cursor's last column/row, so the
// offset is coord + DIM - pos. The result lies inside when it fits in DIM_LOG2 bits.
// Assumes unsigned coordinates. Purely combinational.
module cursor_locate #(
    parameter int COORD_W  = 12,
    parameter int DIM_LOG2 = 6
) (
    input  logic [COORD_W-1:0]  pix_x,
    input  logic [COORD_W-1:0]  pix_y,
    input  logic [COORD_W-1:0]  pos_x,
    input  logic [COORD_W-1:0]  pos_y,
    input  logic                interlace,
    output logic                hit,
    output logic [DIM_LOG2-1:0] col,
    output logic [DIM_LOG2-1:0] row
);
    localparam int EXT_W = COORD_W + 2;
    localparam int DIM   = 1 << DIM_LOG2;

    // Biased offset, wraps to a large value when the pixel is before the window
    function automatic logic [EXT_W-1:0] offset(input logic [COORD_W-1:0] c,
                                               input logic [COORD_W-1:0] p);
        return EXT_W'(c) + EXT_W'(DIM) - EXT_W'(p);
    endfunction

    logic [COORD_W-1:0] pos_y_eff;
    logic [EXT_W-1:0]   dx, dy;
    logic               in_x, in_y;

    // Interlace drops the lowest bit of the vertical position
    always_comb pos_y_eff = interlace ? {pos_y[COORD_W-1:1], 1'b0} : pos_y;

    // Offsets on both axes and range tests
    always_comb begin
        dx   = offset(pix_x, pos_x);
        dy   = offset(pix_y, pos_y_eff);
        in_x = (dx[EXT_W-1:DIM_LOG2] == '0);
        in_y = (dy[EXT_W-1:DIM_LOG2] == '0);
        hit  = in_x && in_y;
        col  = dx[DIM_LOG2-1:0];
        row  = dy[DIM_LOG2-1:0];
    end

endmodule

// File: rtl/cursor_img_ram.sv
// Two-plane cursor image store.
// Plane p holds bytes p*PLANE_BYTES .. (p+1)*PLANE_BYTES-1 of the write space.
// The top address bit selects the plane. A byte holds 8 pixels, MSB leftmost.
// Reads are asynchronous so the overlay adds only its output register.
// Assumes the image is loaded before use. Storage has no reset.
module cursor_img_ram #(
    parameter int DIM_LOG2 = 6
) (
    input  logic                clk,
    input  logic                we,
    input  logic [2*DIM_LOG2-3:0] waddr,
    input  logic [7:0]          wdata,
    input  logic [DIM_LOG2-1:0] rd_row,
    input  logic [DIM_LOG2-1:0] rd_col,
    output logic [1:0]          code
);
    localparam int BIT_LOG2    = 3;
    localparam int PLANE_AW    = 2 * DIM_LOG2 - BIT_LOG2;
    localparam int PLANE_BYTES = 1 << PLANE_AW;
    localparam int AW          = PLANE_AW + 1;

    logic [PLANE_AW-1:0] rd_byte;
    logic [BIT_LOG2-1:0] rd_bit;

    // Byte within the plane and bit within the byte for the pixel read
    always_comb begin
        rd_byte = {rd_row, rd_col[DIM_LOG2-1:BIT_LOG2]};
        rd_bit  = ~rd_col[BIT_LOG2-1:0];
    end

    for (genvar p = 0; p < 2; p++) begin : g_plane
        logic [7:0] mem [PLANE_BYTES];

        // Store a byte when the write addresses this plane
        always_ff @(posedge clk) begin
            if (we && (waddr[AW-1] == 1'(p)))
                mem[waddr[PLANE_AW-1:0]] <= wdata;
        end

        // Pick this plane's bit for the current pixel
        always_comb code[p] = mem[rd_byte][rd_bit];
    end

endmodule

// File: rtl/cursor_clut.sv
// Three-entry cursor colour table with an auto-incrementing byte loader.
// An index write selects an entry and restarts at its red byte. Each data write
// fills R, G, then B. After B the index advances and wraps from the last entry to 0.
// Synchronous active-low reset clears all entries.
module cursor_clut
    import cursor_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_we,
    input  logic       data_we,
    input  logic [7:0] wdata,
    output rgb_t       ovs,
    output rgb_t       back,
    output rgb_t       fore
);
    rgb_t       tbl [CLUT_ENTRIES];
    logic [1:0] idx_q;
    logic [1:0] sub_q;

    // Index and byte-within-entry counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            sub_q <= '0;
        end else if (idx_we) begin
            idx_q <= (wdata[1:0] > CLUT_LAST) ? 2'd0 : wdata[1:0];
            sub_q <= '0;
        end else if (data_we) begin
            if (sub_q == 2'd2) begin
                sub_q <= '0;
                idx_q <= (idx_q == CLUT_LAST) ? 2'd0 : idx_q + 2'd1;
            end else begin
                sub_q <= sub_q + 2'd1;
            end
        end
    end

    // Entry storage, one byte lane per data write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < CLUT_ENTRIES; e++) tbl[e] <= '0;
        end else if (data_we && !idx_we) begin
            for (int e = 0; e < CLUT_ENTRIES; e++) begin
                if (idx_q == 2'(e)) begin
                    case (sub_q)
                        2'd0:    tbl[e].r <= wdata;
                        2'd1:    tbl[e].g <= wdata;
                        default: tbl[e].b <= wdata;
                    endcase
                end
            end
        end
    end

    // Named views of the entries
    always_comb begin
        ovs  = tbl[IDX_OVS];
        back = tbl[IDX_BACK];
        fore = tbl[IDX_FORE];
    end

    // R8
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_q <= CLUT_LAST) && (sub_q <= 2'd2));

    // R8
    idx_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idx_we |=> (sub_q == 2'd0));

    // R8
    entry_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_we && !idx_we && sub_q == 2'd2) |=> (sub_q == 2'd0) &&
        (idx_q == (($past(idx_q) == CLUT_LAST) ? 2'd0 : $past(idx_q) + 2'd1)));

endmodule

// File: rtl/cursor_overlay.sv
// Two-colour 64x64 hardware cursor overlay.
// Per pixel it tests the cursor window, reads the two image planes, decodes
// the code and registers flag, transparency and colour. Latency is one clock.
// Assumes positions are biased by the cursor size (they name the pixel past
// the lower-right corner). Synchronous active-low reset.
module cursor_overlay
    import cursor_pkg::*;
#(
    parameter int COORD_W  = 12,
    parameter int DIM_LOG2 = 6,
    localparam int IMG_AW  = 2 * DIM_LOG2 - 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [COORD_W-1:0] pix_x,
    input  logic [COORD_W-1:0] pix_y,
    input  logic               pix_vld,
    input  logic [COORD_W-1:0] pos_x,
    input  logic [COORD_W-1:0] pos_y,
    input  logic [1:0]         mode,
    input  logic               interlace,
    input  logic               wr_en,
    input  logic [1:0]         wr_kind,
    input  logic [IMG_AW-1:0]  wr_addr,
    input  logic [7:0]         wr_data,
    output logic               curs_act,
    output logic               curs_transp,
    output logic [23:0]        curs_rgb,
    output logic [23:0]        ovs_rgb
);
    wr_kind_e            kind;
    logic                img_we, idx_we, data_we;
    logic                hit;
    logic [DIM_LOG2-1:0] col, row;
    logic [1:0]          code;
    rgb_t                ovs_c, back_c, fore_c;
    logic                enabled, opaque;
    rgb_t                rgb_nxt;

    // Decode the load port into its three write strobes
    always_comb begin
        kind    = wr_kind_e'(wr_kind);
        img_we  = wr_en && (kind == WR_IMAGE);
        idx_we  = wr_en && (kind == WR_CLUT_IDX);
        data_we = wr_en && (kind == WR_CLUT_DATA);
    end

    cursor_locate #(.COORD_W(COORD_W), .DIM_LOG2(DIM_LOG2)) locate_i (
        .pix_x     (pix_x),
        .pix_y     (pix_y),
        .pos_x     (pos_x),
        .pos_y     (pos_y),
        .interlace (interlace),
        .hit       (hit),
        .col       (col),
        .row       (row)
    );

    cursor_img_ram #(.DIM_LOG2(DIM_LOG2)) img_i (
        .clk    (clk),
        .we     (img_we),
        .waddr  (wr_addr),
        .wdata  (wr_data),
        .rd_row (row),
        .rd_col (col),
        .code   (code)
    );

    cursor_clut clut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .idx_we  (idx_we),
        .data_we (data_we),
        .wdata   (wr_data),
        .ovs     (ovs_c),
        .back    (back_c),
        .fore    (fore_c)
    );

    // Qualify the window hit and choose the colour for this pixel
    always_comb begin
        enabled = pix_vld && (mode != 2'b00) && hit;
        opaque  = code_opaque(code);
        if (enabled && opaque)
            rgb_nxt = code[0] ? fore_c : back_c;
        else
            rgb_nxt = '0;
    end

    // Output register: one clock from coordinates to result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            curs_act    <= 1'b0;
            curs_transp <= 1'b0;
            curs_rgb    <= '0;
        end else begin
            curs_act    <= enabled;
            curs_transp <= enabled && !opaque;
            curs_rgb    <= rgb_nxt;
        end
    end

    // Border colour is shown as stored
    always_comb ovs_rgb = ovs_c;

    // R5
    mode_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00) |=> !curs_act);

    // R6
    invalid_pix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_vld |=> !curs_act);

    // R4
    transp_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        curs_transp |-> curs_act);

    // R11
    dark_when_unused_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!curs_act || curs_transp) |-> (curs_rgb == 24'd0));

    // R4
    opaque_from_table_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (curs_act && !curs_transp) |->
        ((curs_rgb == $past(fore_c)) || (curs_rgb == $past(back_c))));

    // R8
    kind_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !$isunknown(wr_kind));

endmodule

// File: tb/cursor_overlay_tb.sv
module cursor_overlay_tb_top;

    typedef struct packed {
        logic [11:0] px;
        logic [11:0] py;
        logic [11:0] qx;
        logic [11:0] qy;
        logic [1:0]  md;
        logic        il;
        logic        vld;
        logic        e_act;
        logic        e_tr;
        logic [23:0] e_rgb;
        logic [3:0]  req;
    } vec_t;

    localparam logic [23:0] FG  = 24'hA1B2C3;
    localparam logic [23:0] BG  = 24'h112233;
    localparam logic [23:0] OVS = 24'h0F1E2D;

    // Cursor at position (200,150): columns 136..199, rows 86..149
    localparam vec_t VECS [19] = '{
        '{12'd136, 12'd86,  12'd200,  12'd150, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0, FG,    4'd3},  // R3 top-left, code 11
        '{12'd137, 12'd86,  12'd200,  12'd150, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0, BG,    4'd4},  // R4 code 10
        '{12'd138, 12'd86,  12'd200,  12'd150, 2'd1, 1'b0, 1'b1, 1'b1, 1'b1, 24'd0, 4'd4},  // R4 code 00
        '{12'd199, 12'd86,  12'd200,  12'd150, 2'd1, 1'b0, 1'b1, 1'b1, 1'b1, 24'd0, 4'd4},  // R4 code 01
        '{12'd199, 12'd149, 12'd200,  12'd150, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0, FG,    4'd2},  // R2 bottom-right corner
        '{12'd136, 12'd87,  12'd200,  12'd150, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0, BG,    4'd3},  // R3 second row
        '{12'd135, 12'd86,  12'd200,  12'd150, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 24'd0, 4'd2},  // R2 left of window
        '{12'd200, 12'd86,  12'd200,  12'd150, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 24'd0, 4'd2},  // R2 right of window
        '{12'd136, 12'd85,  12'd200,  12'd150, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 24'd0, 4'd2},  // R2 above window
        '{12'd136, 12'd150, 12'd200,  12'd150, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 24'd0, 4'd2},  // R2 below window
        '{12'd136, 12'd86,  12'd200,  12'd150, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 24'd0, 4'd5},  // R5 mode off
        '{12'd136, 12'd86,  12'd200,  12'd150, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 24'd0, 4'd6},  // R6 invalid pixel
        '{12'd136, 12'd86,  12'd200,  12'd150, 2'd3, 1'b0, 1'b1, 1'b1, 1'b0, FG,    4'd5},  // R5 other mode
        '{12'd136, 12'd86,  12'd200,  12'd151, 2'd1, 1'b1, 1'b1, 1'b1, 1'b0, FG,    4'd7},  // R7 odd Y, interlaced
        '{12'd136, 12'd86,  12'd200,  12'd151, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 24'd0, 4'd7},  // R7 odd Y, progressive
        '{12'd136, 12'd87,  12'd200,  12'd151, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0, FG,    4'd7},  // R7 progressive row 0
        '{12'd0,   12'd0,   12'd64,   12'd64,  2'd1, 1'b0, 1'b1, 1'b1, 1'b0, FG,    4'd10}, // R10 at origin
        '{12'd0,   12'd0,   12'd10,   12'd64,  2'd1, 1'b0, 1'b1, 1'b1, 1'b1, 24'd0, 4'd10}, // R10 clipped, col 54
        '{12'd4031,12'd86,  12'd4095, 12'd150, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0, FG,    4'd10}  // R10 far right
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] pix_x = '0, pix_y = '0, pos_x = '0, pos_y = '0;
    logic        pix_vld = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic        interlace = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_kind = 2'd3;
    logic [9:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        curs_act, curs_transp;
    logic [23:0] curs_rgb, ovs_rgb;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    cursor_overlay dut_i (
        .clk(clk), .rst_n(rst_n),
        .pix_x(pix_x), .pix_y(pix_y), .pix_vld(pix_vld),
        .pos_x(pos_x), .pos_y(pos_y), .mode(mode), .interlace(interlace),
        .wr_en(wr_en), .wr_kind(wr_kind), .wr_addr(wr_addr), .wr_data(wr_data),
        .curs_act(curs_act), .curs_transp(curs_transp),
        .curs_rgb(curs_rgb), .ovs_rgb(ovs_rgb)
    );

    task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] k, input logic [9:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_kind = k; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_kind = 2'd3;
    endtask

    task automatic pixel(input vec_t v);
        @(negedge clk);
        pix_x = v.px; pix_y = v.py; pos_x = v.qx; pos_y = v.qy;
        mode = v.md; interlace = v.il; pix_vld = v.vld;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 act",    {23'd0, curs_act},    24'd0);
        check("R1 transp", {23'd0, curs_transp}, 24'd0);
        check("R1 rgb",    curs_rgb, 24'd0);
        check("R1 ovs",    ovs_rgb,  24'd0);

        // R8 colour loading: entry 0, then auto-advance into entry 1
        wr(2'b01, '0, 8'd0);
        wr(2'b10, '0, 8'h0F); wr(2'b10, '0, 8'h1E); wr(2'b10, '0, 8'h2D);
        check("R9 ovs after load", ovs_rgb, OVS);
        wr(2'b10, '0, 8'h11); wr(2'b10, '0, 8'h22); wr(2'b10, '0, 8'h33);
        // R8 partial write then index rewrite restarts at red
        wr(2'b10, '0, 8'hEE);
        wr(2'b01, '0, 8'd2);
        wr(2'b10, '0, 8'hA1); wr(2'b10, '0, 8'hB2); wr(2'b10, '0, 8'hC3);
        // R8 wrap from entry 2 to entry 0
        wr(2'b10, '0, 8'h55); wr(2'b10, '0, 8'h66); wr(2'b10, '0, 8'h77);
        check("R8 wrap to entry 0", ovs_rgb, 24'h556677);
        // R8 index 3 selects entry 0
        wr(2'b01, '0, 8'd3);
        wr(2'b10, '0, 8'h0F); wr(2'b10, '0, 8'h1E); wr(2'b10, '0, 8'h2D);
        check("R8 index 3 maps to 0", ovs_rgb, OVS);

        // Image: clear all, then place a few marked bytes
        for (int a = 0; a < 1024; a++) wr(2'b00, 10'(a), 8'h00);
        wr(2'b00, 10'd0,    8'h80);  // plane 0 row 0 byte 0
        wr(2'b00, 10'd512,  8'hC0);  // plane 1 row 0 byte 0
        wr(2'b00, 10'd7,    8'h01);  // plane 0 row 0 byte 7
        wr(2'b00, 10'd511,  8'h01);  // plane 0 row 63 byte 7
        wr(2'b00, 10'd1023, 8'h01);  // plane 1 row 63 byte 7
        wr(2'b00, 10'd520,  8'h80);  // plane 1 row 1 byte 0
        wr(2'b11, 10'd512,  8'h00);  // kind 11 has no effect

        for (int i = 0; i < 19; i++) begin
            string tag;
            pixel(VECS[i]);
            tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
            check({tag, " act"},    {23'd0, curs_act},    {23'd0, VECS[i].e_act});
            check({tag, " transp"}, {23'd0, curs_transp}, {23'd0, VECS[i].e_tr});
            check({tag, " rgb"},    curs_rgb, VECS[i].e_rgb);
        end

        // R2 one-cycle latency: output follows the previous pixel only
        @(negedge clk);
        pix_x = 12'd136; pix_y = 12'd86; pos_x = 12'd200; pos_y = 12'd150;
        mode = 2'd1; interlace = 1'b0; pix_vld = 1'b1;
        @(posedge clk);
        #1 pix_x = 12'd100;
        @(negedge clk);
        check("R2 latency first", curs_rgb, FG);
        @(negedge clk);
        check("R2 latency second", {23'd0, curs_act}, 24'd0);

        // R1 reset during operation
        pix_x = 12'd136;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid-run act", {23'd0, curs_act}, 24'd0);
        check("R1 mid-run ovs", ovs_rgb, 24'd0);
        rst_n = 1'b1;
        @(negedge clk);
        finish_run();
    end

endmodule